// File: doc/BRIEF.md
# Output-Dip Wake Pulse Sequencer

This block sits on the secondary side of an isolated flyback converter, next to a synchronous rectifier gate controller. When the primary side idles for a long time between switching cycles, the output can sag under a sudden load step without the primary controller knowing. The sequencer tells the primary side by emitting a train of short enable pulses for a drain-node current sink. The primary controller can see these pulses through the transformer.

The block watches three inputs. The first is the rectifier gate. The second is a comparator flag that is high while the output is below its trigger level. The third is a one-cycle flag that marks a rising edge on the drain node, which happens when the primary switch turns on.

Every gate rising edge restarts an enable interval. Once that interval has run out, the block may start pulses, but only while the low-output flag is high. Pulse start times are spaced by a fixed re-arm period. Each gate cycle allows only a limited number of pulses. A drain edge ends the train for the rest of the gate cycle. All durations are parameters counted in clock cycles.

Top module: `dip_wake_seq`

## Requirements
- R1: After reset, no pulse starts until a gate rising edge has been sampled. When the clock edge E0 samples the gate going from 0 to 1, the earliest pulse output rises just after edge E0+ARM_CYC+1.
- R2: A pulse that is not cut short keeps `sink_en_o` high for exactly PULSE_CYC clock cycles.
- R3: While `low_supply_i` stays high, consecutive pulses start exactly PERIOD_CYC clock cycles apart.
- R4: When an edge samples `drain_edge_i` high, `sink_en_o` is low after that edge. No further pulse starts until the next gate rising edge. This includes the edge on which the next pulse would otherwise have started.
- R5: At most MAX_PULSES pulses start between two gate rising edges.
- R6: A pulse starts only on an edge that samples `low_supply_i` high. If the flag returns after a gap within the same gate cycle, and the re-arm period has elapsed and the cap is not reached, a pulse starts on the first edge that samples it high.
- R7: A pulse that has started runs its full PULSE_CYC width even if `low_supply_i` drops during it.
- R8: While `rst_n` is low, `sink_en_o` is low.
- R9: A gate rising edge clears the pulse count and the drain stop, and restarts the enable interval. A full new train of MAX_PULSES pulses can then follow.
- R10: A gate rising edge sampled during a pulse ends that pulse at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_i | input | 1 | Rectifier gate level |
| low_supply_i | input | 1 | High while the output is below the trigger level |
| drain_edge_i | input | 1 | One-cycle flag marking a drain rising edge (primary switch on) |
| sink_en_o | output | 1 | Current-sink enable pulse |

## Verification
The block has two collisions that need a test.

The first is a drain edge landing on the same clock edge where the re-arm period ends and the next pulse would start. The bench drives the drain flag so that it is sampled exactly on that restart edge. It then checks that the train holds a single pulse.

The second is a gate rising edge arriving in the middle of a pulse. The bench checks that the pulse is cut to the cycles already elapsed. It also checks that the next pulse appears one full enable interval after the new gate edge, which shows that the abort and the restart both took effect on the same edge.

// File: rtl/dws_pkg.sv
package dws_pkg;
   typedef enum logic {
      DWS_IDLE = 1'b0,
      DWS_RUN  = 1'b1
   } dws_state_e;
endpackage

// File: rtl/dws_arm_timer.sv
module dws_arm_timer #(
   parameter int ARM_CYC = 7200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_i,
   output logic gate_rise_o,
   output logic armed_o
);
   localparam int AW = (ARM_CYC > 0) ? $clog2(ARM_CYC + 1) : 1;

   logic gate_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gate_q <= 1'b0;
      else        gate_q <= gate_i;
   end

   assign gate_rise_o = gate_i & ~gate_q;

   generate
      if (ARM_CYC == 0) begin : g_no_wait
         logic arm_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           arm_q <= 1'b0;
            else if (gate_rise_o) arm_q <= 1'b1;
         end
         assign armed_o = arm_q;
      end else begin : g_wait
         logic          run_q;
         logic [AW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q <= 1'b0;
               cnt_q <= '0;
            end else if (gate_rise_o) begin
               run_q <= 1'b1;
               cnt_q <= '0;
            end else if (run_q && cnt_q != AW'(ARM_CYC)) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         assign armed_o = run_q && (cnt_q == AW'(ARM_CYC));

         AST_ARM_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
            gate_rise_o |=> !armed_o) else $error("arm not restarted"); // R9
      end
   endgenerate
endmodule

// File: rtl/dws_pulse_gen.sv
module dws_pulse_gen
   import dws_pkg::*;
#(
   parameter int PULSE_CYC  = 150,
   parameter int PERIOD_CYC = 400,
   parameter int MAX_PULSES = 14
) (
   input  logic clk,
   input  logic rst_n,
   input  logic armed_i,
   input  logic gate_rise_i,
   input  logic low_i,
   input  logic drain_edge_i,
   output logic sink_o
);
   localparam int PW = $clog2(PERIOD_CYC + 1);
   localparam int CW = $clog2(MAX_PULSES + 1);

   dws_state_e     st_q;
   logic [PW-1:0]  pcnt_q;
   logic [CW-1:0]  npulse_q;
   logic           stop_q;
   logic           can_start;

   assign can_start = armed_i && !stop_q && low_i && (npulse_q < CW'(MAX_PULSES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= DWS_IDLE;
         pcnt_q   <= '0;
         npulse_q <= '0;
         stop_q   <= 1'b0;
      end else if (gate_rise_i) begin
         st_q     <= DWS_IDLE;
         pcnt_q   <= '0;
         npulse_q <= '0;
         stop_q   <= 1'b0;
      end else if (drain_edge_i) begin
         st_q   <= DWS_IDLE;
         pcnt_q <= '0;
         stop_q <= 1'b1;
      end else begin
         case (st_q)
            DWS_IDLE: begin
               if (can_start) begin
                  st_q     <= DWS_RUN;
                  pcnt_q   <= '0;
                  npulse_q <= npulse_q + 1'b1;
               end
            end
            default: begin
               if (pcnt_q == PW'(PERIOD_CYC - 1)) begin
                  pcnt_q <= '0;
                  if (can_start) npulse_q <= npulse_q + 1'b1;
                  else           st_q     <= DWS_IDLE;
               end else begin
                  pcnt_q <= pcnt_q + 1'b1;
               end
            end
         endcase
      end
   end

   assign sink_o = (st_q == DWS_RUN) && (pcnt_q < PW'(PULSE_CYC));

   AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      npulse_q <= CW'(MAX_PULSES)) else $error("pulse cap exceeded"); // R5
   AST_FULL_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sink_o) && !$past(drain_edge_i) && !$past(gate_rise_i)) |-> (pcnt_q == PW'(PULSE_CYC)))
      else $error("pulse cut short"); // R7
   AST_START_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sink_o) |-> $past(low_i)) else $error("start without low flag"); // R6
endmodule

// File: rtl/dip_wake_seq.sv
module dip_wake_seq #(
   parameter int ARM_CYC    = 7200,
   parameter int PULSE_CYC  = 150,
   parameter int PERIOD_CYC = 400,
   parameter int MAX_PULSES = 14
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_i,
   input  logic low_supply_i,
   input  logic drain_edge_i,
   output logic sink_en_o
);
   generate
      if (PULSE_CYC < 1 || PULSE_CYC >= PERIOD_CYC) begin : g_bad_width
         $error("PULSE_CYC must be at least 1 and below PERIOD_CYC");
      end
      if (MAX_PULSES < 1) begin : g_bad_cap
         $error("MAX_PULSES must be at least 1");
      end
      if (ARM_CYC < 0) begin : g_bad_arm
         $error("ARM_CYC must not be negative");
      end
   endgenerate

   logic gate_rise;
   logic armed;

   dws_arm_timer #(.ARM_CYC(ARM_CYC)) u_arm (
      .clk         (clk),
      .rst_n       (rst_n),
      .gate_i      (gate_i),
      .gate_rise_o (gate_rise),
      .armed_o     (armed)
   );

   dws_pulse_gen #(
      .PULSE_CYC  (PULSE_CYC),
      .PERIOD_CYC (PERIOD_CYC),
      .MAX_PULSES (MAX_PULSES)
   ) u_pulse (
      .clk          (clk),
      .rst_n        (rst_n),
      .armed_i      (armed),
      .gate_rise_i  (gate_rise),
      .low_i        (low_supply_i),
      .drain_edge_i (drain_edge_i),
      .sink_o       (sink_en_o)
   );

   AST_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sink_en_o) |-> $past(armed)) else $error("pulse before arm"); // R1
   AST_DRAIN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      drain_edge_i |=> !sink_en_o) else $error("drain edge ignored"); // R4
   AST_GATE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      gate_rise |=> !sink_en_o) else $error("gate edge ignored"); // R10
   AST_RESET_LOW: assert property (@(posedge clk)
      !rst_n |-> !sink_en_o) else $error("output high in reset"); // R8
endmodule

// File: tb/dip_wake_seq_bench.sv
module dip_wake_seq_bench;
   localparam int ARM = 20;
   localparam int PW  = 3;
   localparam int PER = 8;
   localparam int MX  = 4;
   localparam int LAT = ARM + 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic gate = 1'b0;
   logic low = 1'b0;
   logic drain = 1'b0;
   logic sink;

   int cyc = 0;
   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   int rise_c [0:63];
   int wid    [0:63];
   int npulse = 0;
   logic prev = 1'b0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dip_wake_seq #(.ARM_CYC(ARM), .PULSE_CYC(PW), .PERIOD_CYC(PER), .MAX_PULSES(MX)) u_dip_wake_seq (
      .clk(clk), .rst_n(rst_n), .gate_i(gate), .low_supply_i(low),
      .drain_edge_i(drain), .sink_en_o(sink));

   always @(negedge clk) begin
      if (npulse < 64) begin
         if (sink && !prev) rise_c[npulse] = cyc;
         if (!sink && prev) begin
            wid[npulse] = cyc - rise_c[npulse];
            npulse = npulse + 1;
         end
      end
      prev = sink;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_until(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic gate_pulse(output int g);
      g = cyc;
      gate = 1'b1;
      repeat (5) @(negedge clk);
      gate = 1'b0;
   endtask

   task automatic drain_pulse();
      drain = 1'b1;
      @(negedge clk);
      drain = 1'b0;
   endtask

   initial begin
      int g, g2, base, r;
      repeat (3) @(negedge clk);
      chk(sink == 1'b0, "R8", sink, 0);
      rst_n = 1'b1;
      low = 1'b1;
      repeat (40) @(negedge clk);
      chk(npulse == 0, "R1 no gate yet", npulse, 0);

      // R1 R2 R3 R5: full train
      base = npulse;
      gate_pulse(g);
      wait_until(g + 150);
      chk(npulse - base == MX, "R5", npulse - base, MX);
      for (int i = 0; i < MX; i++) begin
         chk(rise_c[base+i] == g + LAT + PER*i, "R1/R3 start", rise_c[base+i], g + LAT + PER*i);
         chk(wid[base+i] == PW, "R2 width", wid[base+i], PW);
      end

      // R9: new gate edge gives a new full train
      base = npulse;
      gate_pulse(g);
      wait_until(g + 150);
      chk(npulse - base == MX, "R9 count", npulse - base, MX);
      chk(rise_c[base] == g + LAT, "R9 first", rise_c[base], g + LAT);

      // R6: flag low, nothing
      low = 1'b0;
      base = npulse;
      gate_pulse(g);
      wait_until(g + 150);
      chk(npulse - base == 0, "R6 idle", npulse - base, 0);

      // R4: drain edge mid second pulse
      low = 1'b1;
      base = npulse;
      gate_pulse(g);
      r = g + LAT;
      wait_until(r + PER + 1);
      drain_pulse();
      wait_until(g + 150);
      chk(npulse - base == 2, "R4 count", npulse - base, 2);
      chk(wid[base] == PW, "R4 first width", wid[base], PW);
      chk(wid[base+1] == 2, "R4 cut width", wid[base+1], 2);

      // R4: drain edge on the restart edge
      base = npulse;
      gate_pulse(g);
      r = g + LAT;
      wait_until(r + PER - 1);
      drain_pulse();
      wait_until(g + 150);
      chk(npulse - base == 1, "R4 restart clash", npulse - base, 1);

      // R7 R6: flag drops mid pulse, later returns
      base = npulse;
      gate_pulse(g);
      r = g + LAT;
      wait_until(r);
      low = 1'b0;
      wait_until(r + 20);
      low = 1'b1;
      wait_until(g + 150);
      chk(wid[base] == PW, "R7 full width", wid[base], PW);
      chk(rise_c[base+1] == r + 21, "R6 resume", rise_c[base+1], r + 21);
      chk(npulse - base == MX, "R6 total", npulse - base, MX);

      // R10: gate edge mid pulse
      base = npulse;
      gate_pulse(g);
      r = g + LAT;
      wait_until(r + 1);
      gate_pulse(g2);
      wait_until(g2 + 150);
      chk(wid[base] == 2, "R10 cut", wid[base], 2);
      chk(rise_c[base+1] == g2 + LAT, "R10 rearm", rise_c[base+1], g2 + LAT);
      chk(npulse - base == 1 + MX, "R10 count", npulse - base, 1 + MX);
      low = 1'b0;

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule